// File: doc/BRIEF.md
# Pseudo-Random Four-Level and Binary Test Pattern Source

This block is an on-chip stimulus source for a four-level receiver. A 16-bit maximal-length shift register produces a pseudo-random bit stream. Each enabled clock, the stream is turned into a 2-bit level code. In four-level mode the code is a random symbol. In binary mode the code toggles between two chosen levels.

The level code is then decoded into a registered thermometer code. That code drives three current-switch gates of an external DAC. More active gates sink more current, so they give a lower output voltage. A level code of 0 switches all gates off and gives the highest voltage. A code of 3 switches all three on and gives the lowest voltage.

Binary mode has four sub-patterns, set by a 2-bit select. Selects 0, 1 and 2 each toggle between one pair of neighbouring levels. Select 3 swings between the two outermost levels. The enable input freezes the whole source, so a pattern can be paused and resumed without a break in the sequence.

Top module: `pam_pattern_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `gate` becomes 3'b000 and the shift register reloads its seed (default 16'hACE1; a zero seed is replaced by 1). The first enabled cycle after reset uses the seed.
- R2: The shift register moves two steps on each enabled clock. Each step shifts the state left by one bit. The bit shifted into bit 0 is the XOR of state bits 15, 13, 12 and 10, which gives the polynomial x^16+x^14+x^13+x^11+1.
- R3: With `bin_mode`=0 (four-level mode), the level code is {state[1], state[0]}. This is the state before that edge's advance, so every enabled clock issues a new symbol. `lvl_sel` has no effect on `gate` in this mode.
- R4: With `bin_mode`=1 and `lvl_sel` = k, where k is 0, 1 or 2, the level code is k + state[0]. The output therefore toggles between levels k and k+1.
- R5: With `bin_mode`=1 and `lvl_sel`=3, the level code is 3 when state[0]=1 and 0 otherwise. This is the full-swing pattern.
- R6: Level code L is decoded to a thermometer code in which `gate[i]` = 1 exactly when L > i. The codes are 0→000, 1→001, 2→011 and 3→111 (written as gate[2:0]). The result is registered, so `gate` updates on the rising edge that samples the inputs.
- R7: While `en`=0, both `gate` and the shift register hold their values. A later enabled cycle continues the sequence from the held state.
- R8: The shift register never holds the all-zero state.
- R9: A change of `bin_mode` or `lvl_sel` takes effect at the next enabled edge. No extra delay is added and no symbol is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the pattern on this edge |
| bin_mode | input | 1 | 0 = four-level symbols, 1 = binary pattern |
| lvl_sel | input | 2 | Binary sub-pattern: 0..2 adjacent pair, 3 full swing |
| gate | output | 3 | Thermometer gate controls; bit 0 is the first gate |

## Verification
The outputs depend on where the pseudo-random sequence happens to be, and it cannot be loaded directly from the ports. So each binary sub-pattern must be run long enough to see both of its levels, and four-level mode must be run until all four codes have appeared. The bench counts the levels seen during each scenario. The hardest case is pausing in the middle of a sequence. The bench drops `en` for several cycles and then resumes. It shows that the shift register was held by matching the symbols that follow against an independent model of the register, which is advanced only on enabled cycles.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int LVL_W  = 2;
  localparam int GATE_N = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0]  level_t;
  typedef logic [GATE_N-1:0] therm_t;

  // Pick the level code from the mode, the select and the random bits.
  function automatic level_t pick_level(input logic bin_mode, input level_t sel,
                                        input level_t sym);
    level_t lv;
    if (!bin_mode)
      lv = sym;
    else if (sel == '1)
      lv = sym[0] ? '1 : '0;
    else
      lv = sel + level_t'(sym[0]);
    return lv;
  endfunction
endpackage

// File: rtl/pgen_lfsr.sv
module pgen_lfsr #(
  parameter int           W     = 16,
  parameter logic [W-1:0] TAPS  = 16'hB400,
  parameter logic [W-1:0] SEED  = 16'hACE1,
  parameter int           STEP  = 2,
  parameter int           OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [OUT_W-1:0] low_bits
);
  localparam logic [W-1:0] SAFE_SEED = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q;

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = s;
    for (int i = 0; i < STEP; i++)
      t = {t[W-2:0], ^(t & TAPS)};
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= SAFE_SEED;
    else if (adv)
      state_q <= advance(state_q);
  end

  assign low_bits = state_q[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state_q != '0); // R8
  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state_q)); // R7
  AST_LFSR_SEEDED: assert property (@(posedge clk)
    rst |=> state_q == SAFE_SEED); // R1
endmodule

// File: rtl/pgen_level_map.sv
module pgen_level_map
  import pgen_pkg::*;
(
  input  logic   bin_mode,
  input  level_t sel,
  input  level_t sym,
  output level_t level
);
  always_comb level = pick_level(bin_mode, sel, sym);
endmodule

// File: rtl/pgen_therm.sv
module pgen_therm #(
  parameter int IN_W  = 2,
  parameter int OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] therm
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_bit
    assign therm[i] = (int'(code) > i);
  end
endmodule

// File: rtl/pam_pattern_gen.sv
module pam_pattern_gen
  import pgen_pkg::*;
#(
  parameter int                LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        bin_mode,
  input  logic [1:0]  lvl_sel,
  output logic [2:0]  gate
);
  level_t sym, level;
  therm_t therm, gate_q;

  pgen_lfsr #(
    .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .STEP(LVL_W), .OUT_W(LVL_W)
  ) u_lfsr (
    .clk(clk), .rst(rst), .adv(en), .low_bits(sym)
  );

  pgen_level_map u_map (
    .bin_mode(bin_mode), .sel(lvl_sel), .sym(sym), .level(level)
  );

  pgen_therm #(.IN_W(LVL_W), .OUT_N(GATE_N)) u_therm (
    .code(level), .therm(therm)
  );

  always_ff @(posedge clk) begin
    if (rst)
      gate_q <= '0;
    else if (en)
      gate_q <= therm;
  end

  assign gate = gate_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> gate == '0); // R1
  AST_THERM_VALID: assert property (@(posedge clk) disable iff (rst)
    (gate == 3'b000) || (gate == 3'b001) || (gate == 3'b011) || (gate == 3'b111)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(gate)); // R7
  AST_FULL_SWING: assert property (@(posedge clk) disable iff (rst)
    (en && bin_mode && lvl_sel == 2'd3) |=> (gate == 3'b000 || gate == 3'b111)); // R5
  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (en && bin_mode && lvl_sel != 2'd3) |=>
      ($countones(gate) == int'($past(lvl_sel)) ||
       $countones(gate) == int'($past(lvl_sel)) + 1)); // R4
endmodule

// File: tb/tb_pam_pattern_gen.sv
module tb_pam_pattern_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       bin_mode = 1'b0;
  logic [1:0] lvl_sel = 2'd0;
  logic [2:0] gate;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] m_state;
  logic [2:0]  m_gate;
  int          seen [4];

  pam_pattern_gen dut (
    .clk(clk), .rst(rst), .en(en), .bin_mode(bin_mode), .lvl_sel(lvl_sel), .gate(gate)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] step2(input logic [15:0] s);
    logic [15:0] t = s;
    for (int i = 0; i < 2; i++)
      t = {t[14:0], t[15] ^ t[13] ^ t[12] ^ t[10]};
    return t;
  endfunction

  function automatic logic [2:0] to_therm(input int l);
    logic [2:0] t;
    for (int i = 0; i < 3; i++) t[i] = (l > i);
    return t;
  endfunction

  function automatic int exp_level(input logic [15:0] s, input logic bm, input logic [1:0] sel);
    if (!bm) return int'(s[1:0]);
    if (sel == 2'd3) return s[0] ? 3 : 0;
    return int'(sel) + int'(s[0]);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s gate actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a falling edge with inputs already set: update model, wait, compare.
  task automatic tick(input string req);
    int l;
    if (rst) begin
      m_state = 16'hACE1;
      m_gate  = 3'b000;
    end else if (en) begin
      l = exp_level(m_state, bin_mode, lvl_sel);
      m_gate  = to_therm(l);
      m_state = step2(m_state);
      seen[l]++;
    end
    @(negedge clk);
    check(req, gate, m_gate);
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 4; i++) seen[i] = 0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    tick("R1");
    tick("R1");
    rst = 1'b0;
    // seed 16'hACE1 has low bits 01: first symbol is level 1
    tick("R1");
    check("R1 first symbol from seed", gate, 3'b001);
  endtask

  task automatic t_pam();
    clear_seen();
    bin_mode = 1'b0; en = 1'b1;
    for (int i = 0; i < 64; i++) begin
      lvl_sel = 2'(i * 3);   // R3: select varies, must not matter
      tick("R2 R3");
    end
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (seen[i] == 0) begin
        failures++;
        $display("FAIL R6 level %0d count actual=0 expected>0", i);
      end
    end
  endtask

  task automatic t_pair(input logic [1:0] k);
    clear_seen();
    bin_mode = 1'b1; lvl_sel = k; en = 1'b1;
    for (int i = 0; i < 40; i++) tick("R4");
    checks++;
    if (seen[k] == 0 || seen[k+1] == 0) begin
      failures++;
      $display("FAIL R4 pair %0d counts actual=%0d,%0d expected both>0", k, seen[k], seen[k+1]);
    end
  endtask

  task automatic t_full();
    clear_seen();
    bin_mode = 1'b1; lvl_sel = 2'd3; en = 1'b1;
    for (int i = 0; i < 40; i++) tick("R5");
    checks++;
    if (seen[0] == 0 || seen[3] == 0 || seen[1] != 0 || seen[2] != 0) begin
      failures++;
      $display("FAIL R5 counts actual=%0d/%0d/%0d/%0d expected only 0 and 3",
               seen[0], seen[1], seen[2], seen[3]);
    end
  endtask

  task automatic t_hold();
    logic [2:0] held;
    bin_mode = 1'b0; en = 1'b1;
    for (int i = 0; i < 5; i++) tick("R7");
    held = gate;
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      bin_mode = ~bin_mode; lvl_sel = 2'(i);
      tick("R7 hold");
      check("R7 stable while idle", gate, held);
    end
    bin_mode = 1'b0; en = 1'b1;
    for (int i = 0; i < 12; i++) tick("R7 resume");
  endtask

  task automatic t_switch();
    en = 1'b1;
    for (int i = 0; i < 32; i++) begin
      bin_mode = i[0];
      lvl_sel  = 2'(i >> 1);
      tick("R9");
    end
  endtask

  task automatic t_mid_reset();
    bin_mode = 1'b1; lvl_sel = 2'd3; en = 1'b0;
    rst = 1'b1;
    tick("R1 reset while idle");
    rst = 1'b0; bin_mode = 1'b0; en = 1'b1;
    tick("R1 reseed");
    check("R1 reseed symbol", gate, 3'b001);
    for (int i = 0; i < 8; i++) tick("R2 after reseed");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pam();
    t_pair(2'd0);
    t_pair(2'd1);
    t_pair(2'd2);
    t_full();
    t_hold();
    t_switch();
    t_mid_reset();
    finish_run();
  end
endmodule